// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a synchronous word memory built for a pipelined bus protocol. The command (address, direction, byte enables and advance/load strobe) is registered on a rising clock edge. The data transfer for that command happens during the following cycle. Write data is sampled on the next enabled edge, and read data flows combinationally out of the array. Because every command has the same one-cycle lag, reads and writes can be interleaved on consecutive cycles with no idle cycle between them.

A built-in four-beat sequencer continues a transfer from one loaded address. The two low address bits step in either wrapping linear order or exclusive-or interleaved order, chosen by a static input. Three chip enables with mixed polarity gate new commands. A clock enable freezes the whole block as if the edge had been removed. An asynchronous output enable gates the read driver. The bidirectional data pin is split into a write bus, a read bus and a drive flag.

Top module: `zbt_sram_core`

## Requirements
- R1: A load cycle (`adv`=0, cke_n=0, chip selected) with `we_n`=1 registers a read. During the next cycle `rdrive`=1 and `rdata` equals the word stored at the loaded address.
- R2: A load cycle with `we_n`=0 registers a write. `wdata` is sampled at the next enabled edge. Lane k is data bits [8k+7:8k] plus bit 32+k, and it is written only when `bwe_n[k]`=0. Other lanes keep their contents.
- R3: Reads and writes may alternate on consecutive cycles. A read loaded on the edge that completes a write to the same address returns the new data.
- R4: The chip is selected only when `sel1_n`=0, `sel2_n`=0 and `sel3`=1. A load cycle with any of these false is a deselect. In the following cycle `rdrive`=0 and `rdata`=0.
- R5: A write already in flight when a deselect is sampled still completes.
- R6: `adv`=1 with no transfer sequence active (after reset or after a deselect) is a no-operation. `rdrive` stays 0.
- R7: Each `adv`=1 cycle within a sequence moves to the next beat while keeping the upper address bits. Beat n uses low bits (base+n) mod 4 when `order_ilv`=0, and base XOR n when `order_ilv`=1. The sequence wraps after four beats.
- R8: `we_n` is ignored on advance cycles. The direction chosen at load applies to every beat.
- R9: With `cke_n`=1 at an edge, no register changes and the outputs hold. A pending write is deferred to the next enabled edge, and its data is sampled there.
- R10: `oe_n`=1 forces `rdrive`=0 and `rdata`=0 at once, without waiting for a clock edge.
- R11: `rdrive` is 1 only in the data cycle of a read. It is never 1 in a write data cycle.
- R12: After reset, no command is pending and `rdrive`=0.
- R13: Byte enables are captured with each command and each beat, one cycle ahead of the data they qualify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Clock enable, active low; high swallows the edge |
| addr | input | AW | Word address, used on load cycles |
| we_n | input | 1 | Direction at load: 1 read, 0 write |
| adv | input | 1 | 0 loads a new command, 1 advances the sequence |
| sel1_n | input | 1 | Chip enable, active low |
| sel2_n | input | 1 | Chip enable, active low |
| sel3 | input | 1 | Chip enable, active high |
| bwe_n | input | LANES | Per-lane write enables, active low |
| order_ilv | input | 1 | Beat order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*(LANE_W+1) | Write data for the command of the previous cycle |
| rdata | output | LANES*(LANE_W+1) | Flow-through read data, zero when not driven |
| rdrive | output | 1 | Read driver enable |

## Verification
The results of a command issued before edge N are due just after edge N. At that point `rdrive` and `rdata` reflect that command. A write lands at edge N+1, so it becomes visible through a read loaded on that same edge, one cycle after the write's data cycle. The bench drives and samples one time unit after each rising edge and checks every command's outputs in that same window. Frozen edges add no cycles to this count. The output-enable check samples within the cycle, with no edge in between, because that path is combinational.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zbt_burst_seq.sv
`timescale 1ns/1ps
module zbt_burst_seq #(
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic          step,
  input  logic [BW-1:0] base,
  input  logic          ilv,
  output logic [BW-1:0] next_lsb
);
  logic [BW-1:0] base_q, base_d;
  logic [BW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] cnt_nx;

  assign cnt_nx   = cnt_q + 1'b1;
  assign next_lsb = ilv ? (base_q ^ cnt_nx) : (base_q + cnt_nx);

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = base;
      cnt_d  = '0;
    end else if (step) begin
      cnt_d = cnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // R7
  beat_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step && !load) |=> (next_lsb != $past(next_lsb)));
endmodule

// File: rtl/zbt_cmd_ctrl.sv
`timescale 1ns/1ps
module zbt_cmd_ctrl
  import zbt_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int BW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_n,
  input  logic             adv,
  input  logic             we_n,
  input  logic             sel1_n,
  input  logic             sel2_n,
  input  logic             sel3,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] bwe_n,
  input  logic             ilv,
  output op_e              op_q,
  output logic [AW-1:0]    addr_q,
  output logic [LANES-1:0] bwe_q
);
  op_e              op_d, dir_q, dir_d;
  logic [AW-1:0]    addr_d;
  logic [LANES-1:0] bwe_d;
  logic             burst_q, burst_d;
  logic             selected, en, load, step;
  logic [BW-1:0]    next_lsb;

  assign selected = !sel1_n && !sel2_n && sel3;
  assign en       = !cke_n;
  assign load     = !adv && selected;
  assign step     = adv && burst_q;

  zbt_burst_seq #(.BW(BW)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .load     (load),
    .step     (step),
    .base     (addr[BW-1:0]),
    .ilv      (ilv),
    .next_lsb (next_lsb)
  );

  always_comb begin
    op_d    = OP_IDLE;
    dir_d   = dir_q;
    addr_d  = addr_q;
    bwe_d   = bwe_n;
    burst_d = burst_q;
    if (!adv) begin
      if (selected) begin
        op_d    = we_n ? OP_READ : OP_WRITE;
        dir_d   = op_d;
        addr_d  = addr;
        burst_d = 1'b1;
      end else begin
        burst_d = 1'b0;
      end
    end else if (burst_q) begin
      op_d   = dir_q;
      addr_d = {addr_q[AW-1:BW], next_lsb};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      dir_q   <= OP_IDLE;
      addr_q  <= '0;
      bwe_q   <= '1;
      burst_q <= 1'b0;
    end else if (en) begin
      op_q    <= op_d;
      dir_q   <= dir_d;
      addr_q  <= addr_d;
      bwe_q   <= bwe_d;
      burst_q <= burst_d;
    end
  end

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(op_q) && $stable(addr_q) && $stable(burst_q) && $stable(bwe_q)));

  // R4
  desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && (sel1_n || sel2_n || !sel3)) |=> (op_q == OP_IDLE));

  // R6
  noop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv && !burst_q) |=> (op_q == OP_IDLE));

  // R8
  dir_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && adv && burst_q) |=> (op_q == $past(op_q)));
endmodule

// File: rtl/zbt_lane_array.sv
`timescale 1ns/1ps
module zbt_lane_array #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                         clk,
  input  logic                         wen,
  input  logic [AW-1:0]                addr,
  input  logic [LANES-1:0]             bwe_n,
  input  logic [LANES*(LANE_W+1)-1:0]  wdata,
  output logic [LANES*(LANE_W+1)-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int PBASE = LANES * LANE_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W:0] mem [DEPTH];
    logic [LANE_W:0] din;
    logic [LANE_W:0] dout;

    assign din  = {wdata[PBASE+k], wdata[k*LANE_W +: LANE_W]};
    assign dout = mem[addr];

    always_ff @(posedge clk) begin
      if (wen && !bwe_n[k]) begin
        mem[addr] <= din;
      end
    end

    assign rdata[k*LANE_W +: LANE_W] = dout[LANE_W-1:0];
    assign rdata[PBASE+k]            = dout[LANE_W];
  end
endmodule

// File: rtl/zbt_sram_core.sv
`timescale 1ns/1ps
module zbt_sram_core
  import zbt_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int BW     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cke_n,
  input  logic [AW-1:0]                addr,
  input  logic                         we_n,
  input  logic                         adv,
  input  logic                         sel1_n,
  input  logic                         sel2_n,
  input  logic                         sel3,
  input  logic [LANES-1:0]             bwe_n,
  input  logic                         order_ilv,
  input  logic                         oe_n,
  input  logic [LANES*(LANE_W+1)-1:0]  wdata,
  output logic [LANES*(LANE_W+1)-1:0]  rdata,
  output logic                         rdrive
);
  localparam int DW = LANES * (LANE_W + 1);

  op_e              op_q;
  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] bwe_q;
  logic [DW-1:0]    arr_out;
  logic             wen;

  zbt_cmd_ctrl #(.AW(AW), .LANES(LANES), .BW(BW)) i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .cke_n  (cke_n),
    .adv    (adv),
    .we_n   (we_n),
    .sel1_n (sel1_n),
    .sel2_n (sel2_n),
    .sel3   (sel3),
    .addr   (addr),
    .bwe_n  (bwe_n),
    .ilv    (order_ilv),
    .op_q   (op_q),
    .addr_q (addr_q),
    .bwe_q  (bwe_q)
  );

  assign wen = !cke_n && (op_q == OP_WRITE);

  zbt_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_array (
    .clk   (clk),
    .wen   (wen),
    .addr  (addr_q),
    .bwe_n (bwe_q),
    .wdata (wdata),
    .rdata (arr_out)
  );

  assign rdrive = (op_q == OP_READ) && !oe_n;
  assign rdata  = rdrive ? arr_out : '0;

  // R11
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_WRITE) |-> !rdrive);

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rdrive && (rdata == '0)));
endmodule

// File: tb/test_zbt_sram_core.sv
`timescale 1ns/1ps
module test_zbt_sram_core;
  localparam int AW = 8;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n;
  logic cke_n, we_n, adv, sel1_n, sel2_n, sel3, order_ilv, oe_n;
  logic [AW-1:0] addr;
  logic [3:0]    bwe_n;
  logic [DW-1:0] wdata, rdata;
  logic          rdrive;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] model [0:255];

  always #2 clk = ~clk;

  zbt_sram_core i_zbt_sram_core (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .addr(addr), .we_n(we_n),
    .adv(adv), .sel1_n(sel1_n), .sel2_n(sel2_n), .sel3(sel3), .bwe_n(bwe_n),
    .order_ilv(order_ilv), .oe_n(oe_n), .wdata(wdata), .rdata(rdata),
    .rdrive(rdrive)
  );

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // ce: clock enabled; ld: load (adv low); rd: we_n value; s: 0 selected, 1..3 which enable is false
  task automatic cmd(input bit ce, input bit ld, input bit rd, input int s,
                     input logic [AW-1:0] a, input logic [3:0] be, input logic [DW-1:0] wd);
    cke_n  = !ce;
    adv    = !ld;
    we_n   = rd;
    sel1_n = (s == 1);
    sel2_n = (s == 2);
    sel3   = (s != 3);
    addr   = a;
    bwe_n  = be;
    wdata  = wd;
    @(posedge clk);
    #1;
  endtask

  task automatic mw(input logic [AW-1:0] a, input logic [3:0] be, input logic [DW-1:0] d);
    for (int k = 0; k < 4; k++) begin
      if (!be[k]) begin
        model[a][8*k +: 8] = d[8*k +: 8];
        model[a][32+k]     = d[32+k];
      end
    end
  endtask

  function automatic logic [DW-1:0] vpat(input int i);
    return {i[3:0], 32'hC0DE_0000 + i};
  endfunction

  localparam logic [DW-1:0] P0 = 36'h9_1234_5678;
  localparam logic [DW-1:0] P1 = 36'h6_8765_4321;
  localparam logic [DW-1:0] JK = 36'hF_FFFF_FFFF;

  task automatic t_reset;
    rst_n = 1'b0; cke_n = 1'b0; adv = 1'b1; we_n = 1'b1;
    sel1_n = 1'b0; sel2_n = 1'b0; sel3 = 1'b1; order_ilv = 1'b0; oe_n = 1'b0;
    addr = '0; bwe_n = 4'hF; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R12 drive after reset", {35'd0, rdrive}, 36'd0);
    chk("R12 data after reset", rdata, 36'd0);
    cmd(1, 0, 1, 0, 8'h00, 4'hF, '0);
    chk("R6 advance after reset is no-op", {35'd0, rdrive}, 36'd0);
  endtask

  task automatic t_alternate;
    cmd(1, 1, 0, 0, 8'h10, 4'h0, '0);
    chk("R11 no drive in write data cycle", {35'd0, rdrive}, 36'd0);
    cmd(1, 1, 1, 0, 8'h10, 4'hF, P0); mw(8'h10, 4'h0, P0);
    chk("R1 read drive", {35'd0, rdrive}, 36'd1);
    chk("R3 read right after write", rdata, model[8'h10]);
    cmd(1, 1, 0, 0, 8'h11, 4'h0, JK);
    chk("R11 write after read no drive", {35'd0, rdrive}, 36'd0);
    cmd(1, 1, 1, 0, 8'h11, 4'hF, P1); mw(8'h11, 4'h0, P1);
    chk("R3 alternate read", rdata, model[8'h11]);
    cmd(1, 1, 1, 0, 8'h10, 4'h0, JK);
    chk("R1 older word unchanged", rdata, model[8'h10]);
  endtask

  task automatic t_lanes;
    cmd(1, 1, 0, 0, 8'h10, 4'b1010, '0);
    cmd(1, 1, 1, 0, 8'h10, 4'hF, JK); mw(8'h10, 4'b1010, JK);
    chk("R2 lanes 0 and 2 only", rdata, model[8'h10]);
  endtask

  task automatic t_burst;
    cmd(1, 1, 0, 0, 8'h20, 4'h0, '0);
    for (int i = 1; i < 4; i++) begin
      cmd(1, 1, 0, 0, 8'h20 + 8'(i), 4'h0, vpat(i-1));
      mw(8'h20 + 8'(i-1), 4'h0, vpat(i-1));
    end
    cmd(1, 1, 1, 1, 8'h00, 4'hF, vpat(3)); mw(8'h23, 4'h0, vpat(3));
    order_ilv = 1'b0;
    cmd(1, 1, 1, 0, 8'h22, 4'hF, '0);
    chk("R7 linear beat 0", rdata, vpat(2));
    cmd(1, 0, 0, 0, 8'h00, 4'h0, JK);
    chk("R8 we_n ignored on advance", {35'd0, rdrive}, 36'd1);
    chk("R7 linear beat 1", rdata, vpat(3));
    cmd(1, 0, 0, 0, 8'h00, 4'h0, JK);
    chk("R7 linear beat 2 wraps", rdata, vpat(0));
    cmd(1, 0, 1, 0, 8'h00, 4'h0, JK);
    chk("R7 linear beat 3", rdata, vpat(1));
    cmd(1, 0, 1, 0, 8'h00, 4'h0, JK);
    chk("R7 linear sequence restarts", rdata, vpat(2));
    order_ilv = 1'b1;
    cmd(1, 1, 1, 0, 8'h21, 4'hF, '0);
    chk("R7 interleaved beat 0", rdata, vpat(1));
    cmd(1, 0, 1, 0, 8'h00, 4'hF, '0);
    chk("R7 interleaved beat 1", rdata, vpat(0));
    cmd(1, 0, 1, 0, 8'h00, 4'hF, '0);
    chk("R7 interleaved beat 2", rdata, vpat(3));
    cmd(1, 0, 1, 0, 8'h00, 4'hF, '0);
    chk("R7 interleaved beat 3", rdata, vpat(2));
    order_ilv = 1'b0;
    cmd(1, 1, 0, 0, 8'h20, 4'b0000, '0);
    cmd(1, 0, 1, 0, 8'h00, 4'b1110, 36'hA_1111_2222); mw(8'h20, 4'b0000, 36'hA_1111_2222);
    chk("R8 burst write stays write", {35'd0, rdrive}, 36'd0);
    cmd(1, 0, 1, 0, 8'h00, 4'b0111, 36'h5_3333_4444); mw(8'h21, 4'b1110, 36'h5_3333_4444);
    cmd(1, 1, 1, 2, 8'h00, 4'hF, 36'h3_5555_6666);    mw(8'h22, 4'b0111, 36'h3_5555_6666);
    cmd(1, 1, 1, 0, 8'h20, 4'hF, '0);
    chk("R13 beat 0 full word", rdata, model[8'h20]);
    cmd(1, 1, 1, 0, 8'h21, 4'hF, '0);
    chk("R13 beat 1 lane 0 only", rdata, model[8'h21]);
    cmd(1, 1, 1, 0, 8'h22, 4'hF, '0);
    chk("R13 beat 2 lane 3 only", rdata, model[8'h22]);
  endtask

  task automatic t_deselect;
    cmd(1, 1, 0, 0, 8'h30, 4'h0, '0);
    cmd(1, 1, 1, 1, 8'h00, 4'hF, P1); mw(8'h30, 4'h0, P1);
    chk("R4 deselect floats bus", {35'd0, rdrive}, 36'd0);
    cmd(1, 1, 1, 0, 8'h30, 4'hF, '0);
    chk("R5 pending write completed", rdata, model[8'h30]);
    cmd(1, 1, 1, 3, 8'h00, 4'hF, '0);
    chk("R4 deselect by sel3", {35'd0, rdrive}, 36'd0);
    chk("R4 data zero when deselected", rdata, 36'd0);
    cmd(1, 0, 1, 0, 8'h00, 4'hF, '0);
    chk("R6 advance after deselect is no-op", {35'd0, rdrive}, 36'd0);
    cmd(1, 1, 1, 0, 8'h11, 4'hF, '0);
    cmd(1, 1, 1, 2, 8'h00, 4'hF, '0);
    chk("R4 deselect by sel2_n", {35'd0, rdrive}, 36'd0);
  endtask

  task automatic t_freeze;
    cmd(1, 1, 1, 0, 8'h11, 4'hF, '0);
    chk("R9 read before freeze", rdata, model[8'h11]);
    cmd(0, 1, 0, 3, 8'h10, 4'h0, JK);
    chk("R9 frozen drive held", {35'd0, rdrive}, 36'd1);
    chk("R9 frozen data held", rdata, model[8'h11]);
    cmd(0, 1, 1, 0, 8'h10, 4'h0, JK);
    chk("R9 second frozen edge", rdata, model[8'h11]);
    cmd(1, 1, 0, 0, 8'h40, 4'h0, '0);
    cmd(0, 1, 1, 0, 8'h41, 4'hF, JK);
    cmd(0, 1, 1, 0, 8'h41, 4'hF, JK);
    cmd(1, 1, 1, 0, 8'h40, 4'hF, P0); mw(8'h40, 4'h0, P0);
    chk("R9 write deferred to enabled edge", rdata, model[8'h40]);
  endtask

  task automatic t_oe;
    cmd(1, 1, 1, 0, 8'h40, 4'hF, '0);
    oe_n = 1'b1; #1;
    chk("R10 oe high drive off", {35'd0, rdrive}, 36'd0);
    chk("R10 oe high data zero", rdata, 36'd0);
    oe_n = 1'b0; #1;
    chk("R10 oe low data back", rdata, model[8'h40]);
  endtask

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_alternate();
    t_lanes();
    t_burst();
    t_deselect();
    t_freeze();
    t_oe();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule